// File: doc/BRIEF.md
# Coherence Response Classifier with Pending-Ack Counter

This block sits at the response input of a first-level cache controller. For the response at the head of the queue it names one coherence event. It also keeps the signed count of invalidation acknowledgements still owed to the open transaction. The block looks at four inputs: the response kind, the signed ack count the message carries, a flag that marks a peer first-level cache as the sender, and the current line state. From these it picks the event the controller's transition logic will act on.

The event is combinational. It comes from the message and the counter value as they stand in that cycle. When the controller pops a response that settles acks, the counter moves on the following clock edge by the message's count. Freeing the transaction returns the counter to zero. The counter is signed, so a data response carrying a negative count may arrive before or after the individual acks and still balance to zero.

Top module: `coh_rsp_unit`

## Requirements
- R1: After reset the pending count reads 0. While `rsp_valid_i` is low, `evt_valid_o` and `err_o` are both 0.
- R2: A response of kind 1 (exclusive data) yields event 2, whatever the ack count, sender or line state.
- R3: A response of kind 0 (data) from a peer cache, while the line state is one of the read-pending codes 5, 6, 11 or 14, yields event 3.
- R4: Any other kind-0 response yields event 4 when the pending count minus the message's ack count is zero, and event 1 otherwise.
- R5: A response of kind 2 (ack) yields event 6 when the pending count minus the ack count is zero, and event 5 otherwise.
- R6: A response of kind 3 (writeback ack) yields event 7.
- R7: Kinds 4 to 7 raise `err_o`, hold `evt_valid_o` low and put event 0 on `evt_o`.
- R8: Popping a response classified as event 1, 4, 5 or 6 makes the pending count one cycle later equal to the old count minus the message's ack count. Popping any other event leaves the count unchanged.
- R9: `free_i` sets the pending count to 0 one cycle later and takes priority over a pop in the same cycle.
- R10: Arithmetic is signed two's complement. A data count of -2 followed by two acks of 1 gives events 1, 5, 6. Two acks of 1 followed by data of -2 gives events 5, 5, 4, and the count ends at 0.
- R11: `pop_i` has no effect on the count while `rsp_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsp_valid_i | input | 1 | A response is present |
| rsp_kind_i | input | 3 | Response kind code |
| rsp_ack_cnt_i | input | CNT_W | Signed ack count carried by the message |
| rsp_from_peer_i | input | 1 | Sender is a peer first-level cache |
| line_state_i | input | ST_W | Current state code of the addressed line |
| pop_i | input | 1 | Controller consumes the response this cycle |
| free_i | input | 1 | Transaction released; clear the count |
| evt_valid_o | output | 1 | `evt_o` carries a legal event |
| evt_o | output | 3 | Classified event code |
| err_o | output | 1 | Illegal response kind |
| pend_cnt_o | output | CNT_W | Signed pending-ack count |

## Verification
Event, valid and error outputs are combinational. They are due in the same cycle the response is driven, so the bench drives on the falling edge and samples one time unit later, before any rising edge. The pending count is registered. Its effect from a pop or a free is due after exactly one rising edge, so the bench reads it at the next falling edge. At that point it also checks the classification of the following message against the new count. Sequences with negative counts in both arrival orders confirm that the same zero crossing is reached either way.

// File: rtl/coh_rsp_pkg.sv
package coh_rsp_pkg;
  localparam int KIND_W = 3;
  localparam int EVT_W  = 3;

  localparam logic [KIND_W-1:0] KIND_DATA      = 3'd0;
  localparam logic [KIND_W-1:0] KIND_DATA_EXCL = 3'd1;
  localparam logic [KIND_W-1:0] KIND_ACK       = 3'd2;
  localparam logic [KIND_W-1:0] KIND_WB_ACK    = 3'd3;

  typedef enum logic [EVT_W-1:0] {
    EV_NONE      = 3'd0,
    EV_DATA_WAIT = 3'd1,
    EV_DATA_EXCL = 3'd2,
    EV_DATA_PEER = 3'd3,
    EV_DATA_DONE = 3'd4,
    EV_ACK       = 3'd5,
    EV_ACK_LAST  = 3'd6,
    EV_WB_ACK    = 3'd7
  } evt_e;

  // read-pending line states: demand, demand+inv, prefetch, prefetch+inv
  localparam logic [3:0] ST_RD_WAIT    = 4'd5;
  localparam logic [3:0] ST_RD_WAIT_IV = 4'd6;
  localparam logic [3:0] ST_PF_RD      = 4'd11;
  localparam logic [3:0] ST_PF_RD_IV   = 4'd14;

  function automatic logic is_rd_wait(input logic [3:0] st);
    return (st == ST_RD_WAIT) || (st == ST_RD_WAIT_IV) ||
           (st == ST_PF_RD)   || (st == ST_PF_RD_IV);
  endfunction
endpackage

// File: rtl/coh_rsp_classify.sv
module coh_rsp_classify
  import coh_rsp_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ST_W  = 4
) (
  input  logic                    valid_i,
  input  logic [KIND_W-1:0]       kind_i,
  input  logic signed [CNT_W-1:0] ack_i,
  input  logic                    peer_i,
  input  logic [ST_W-1:0]         state_i,
  input  logic signed [CNT_W-1:0] pend_i,
  output logic                    evt_valid_o,
  output evt_e                    evt_o,
  output logic                    err_o,
  output logic                    settles_o
);
  logic signed [CNT_W-1:0] left;
  logic                    none_left;
  logic [3:0]              st4;

  assign left      = pend_i - ack_i;
  assign none_left = (left == '0);
  assign st4       = 4'(state_i);

  always_comb begin
    evt_valid_o = 1'b0;
    evt_o       = EV_NONE;
    err_o       = 1'b0;
    settles_o   = 1'b0;
    if (valid_i) begin
      evt_valid_o = 1'b1;
      unique case (kind_i)
        KIND_DATA_EXCL: evt_o = EV_DATA_EXCL;
        KIND_DATA: begin
          if (peer_i && is_rd_wait(st4)) begin
            evt_o = EV_DATA_PEER;
          end else begin
            evt_o     = none_left ? EV_DATA_DONE : EV_DATA_WAIT;
            settles_o = 1'b1;
          end
        end
        KIND_ACK: begin
          evt_o     = none_left ? EV_ACK_LAST : EV_ACK;
          settles_o = 1'b1;
        end
        KIND_WB_ACK: evt_o = EV_WB_ACK;
        default: begin
          evt_valid_o = 1'b0;
          err_o       = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/coh_ack_ctr.sv
module coh_ack_ctr #(
  parameter int CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    free_i,
  input  logic                    upd_i,
  input  logic signed [CNT_W-1:0] dec_i,
  output logic signed [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (free_i) cnt_o <= '0;
    else if (upd_i)  cnt_o <= cnt_o - dec_i;
  end

  a_r9_free_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |=> cnt_o == '0);
endmodule

// File: rtl/coh_rsp_unit.sv
module coh_rsp_unit
  import coh_rsp_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ST_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rsp_valid_i,
  input  logic [2:0]              rsp_kind_i,
  input  logic signed [CNT_W-1:0] rsp_ack_cnt_i,
  input  logic                    rsp_from_peer_i,
  input  logic [ST_W-1:0]         line_state_i,
  input  logic                    pop_i,
  input  logic                    free_i,
  output logic                    evt_valid_o,
  output logic [2:0]              evt_o,
  output logic                    err_o,
  output logic signed [CNT_W-1:0] pend_cnt_o
);
  evt_e evt;
  logic settles;
  logic cnt_upd;

  coh_rsp_classify #(.CNT_W(CNT_W), .ST_W(ST_W)) u_cls (
    .valid_i     (rsp_valid_i),
    .kind_i      (rsp_kind_i),
    .ack_i       (rsp_ack_cnt_i),
    .peer_i      (rsp_from_peer_i),
    .state_i     (line_state_i),
    .pend_i      (pend_cnt_o),
    .evt_valid_o (evt_valid_o),
    .evt_o       (evt),
    .err_o       (err_o),
    .settles_o   (settles)
  );

  assign evt_o   = evt;
  assign cnt_upd = pop_i & settles;

  coh_ack_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .free_i (free_i),
    .upd_i  (cnt_upd),
    .dec_i  (rsp_ack_cnt_i),
    .cnt_o  (pend_cnt_o)
  );

  logic settling_evt;
  assign settling_evt = evt_valid_o && (evt == EV_DATA_WAIT || evt == EV_DATA_DONE ||
                                        evt == EV_ACK || evt == EV_ACK_LAST);

  a_r7_err_no_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !evt_valid_o && evt_o == 3'd0);

  a_r2_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_kind_i == KIND_DATA_EXCL) |-> evt_valid_o && evt_o == 3'd2);

  a_r5_ack_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_o == 3'd6) |-> pend_cnt_o == rsp_ack_cnt_i);

  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && settling_evt && !free_i) |=>
      pend_cnt_o == $past(pend_cnt_o) - $past(rsp_ack_cnt_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_i && !(pop_i && settling_evt)) |=> $stable(pend_cnt_o));

  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |-> !evt_valid_o && !err_o);
endmodule

// File: tb/coh_rsp_unit_tb_top.sv
module coh_rsp_unit_tb_top;
  localparam int CNT_W = 8;
  localparam int ST_W  = 4;
  localparam int NV    = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rsp_valid_i, rsp_from_peer_i, pop_i, free_i;
  logic [2:0] rsp_kind_i;
  logic signed [CNT_W-1:0] rsp_ack_cnt_i;
  logic [ST_W-1:0] line_state_i;
  logic evt_valid_o, err_o;
  logic [2:0] evt_o;
  logic signed [CNT_W-1:0] pend_cnt_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  coh_rsp_unit #(.CNT_W(CNT_W), .ST_W(ST_W)) dut_i (
    .clk_i, .rst_ni, .rsp_valid_i, .rsp_kind_i, .rsp_ack_cnt_i,
    .rsp_from_peer_i, .line_state_i, .pop_i, .free_i,
    .evt_valid_o, .evt_o, .err_o, .pend_cnt_o
  );

  // {req[3:0], kind[2:0], ack[7:0], peer, state[3:0], exp_evt[2:0], exp_err}
  localparam logic [23:0] VECS [NV] = '{
    {4'd2,  3'd1, 8'd0,   1'b1, 4'd5,  3'd2, 1'b0}, // R2
    {4'd2,  3'd1, 8'd3,   1'b0, 4'd0,  3'd2, 1'b0}, // R2
    {4'd3,  3'd0, 8'd0,   1'b1, 4'd5,  3'd3, 1'b0}, // R3
    {4'd3,  3'd0, 8'd2,   1'b1, 4'd14, 3'd3, 1'b0}, // R3
    {4'd3,  3'd0, 8'd0,   1'b1, 4'd11, 3'd3, 1'b0}, // R3
    {4'd3,  3'd0, 8'd0,   1'b1, 4'd6,  3'd3, 1'b0}, // R3
    {4'd4,  3'd0, 8'd0,   1'b1, 4'd7,  3'd4, 1'b0}, // R4 not read-pending
    {4'd4,  3'd0, 8'd0,   1'b0, 4'd5,  3'd4, 1'b0}, // R4 not from peer
    {4'd4,  3'd0, 8'd3,   1'b0, 4'd7,  3'd1, 1'b0}, // R4
    {4'd4,  3'd0, 8'hFF,  1'b1, 4'd2,  3'd1, 1'b0}, // R4
    {4'd5,  3'd2, 8'd0,   1'b0, 4'd7,  3'd6, 1'b0}, // R5
    {4'd5,  3'd2, 8'd1,   1'b0, 4'd7,  3'd5, 1'b0}, // R5
    {4'd6,  3'd3, 8'd4,   1'b1, 4'd9,  3'd7, 1'b0}, // R6
    {4'd7,  3'd4, 8'd0,   1'b0, 4'd0,  3'd0, 1'b1}, // R7
    {4'd7,  3'd7, 8'd1,   1'b1, 4'd5,  3'd0, 1'b1}, // R7
    {4'd7,  3'd5, 8'd0,   1'b0, 4'd7,  3'd0, 1'b1}  // R7
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic signed [7:0] a, input logic p,
                       input logic [3:0] s, input logic v, input logic pp, input logic fr);
    rsp_kind_i = k; rsp_ack_cnt_i = a; rsp_from_peer_i = p; line_state_i = s;
    rsp_valid_i = v; pop_i = pp; free_i = fr;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    drive(3'd0, 8'sd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk("R1 count", int'(pend_cnt_o), 0);
    chk("R1 evt_valid", int'(evt_valid_o), 0);
    chk("R1 err", int'(err_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VECS[i];
      drive(v[19:17], v[16:9], v[8], v[7:4], 1'b1, 1'b0, 1'b0);
      #1;
      chk($sformatf("R%0d row %0d evt", v[23:20], i), int'(evt_o), int'(v[3:1]));
      chk($sformatf("R%0d row %0d err", v[23:20], i), int'(err_o), int'(v[0]));
      chk($sformatf("R%0d row %0d valid", v[23:20], i), int'(evt_valid_o), int'(!v[0]));
      @(negedge clk_i);
    end

    // R10: negative data count first, then acks
    drive(3'd0, -8'sd2, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0); #1;
    chk("R10 data first evt", int'(evt_o), 1);
    step();
    chk("R8 count after data", int'(pend_cnt_o), 2);
    drive(3'd2, 8'sd1, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0); #1;
    chk("R10 ack one evt", int'(evt_o), 5);
    step();
    chk("R8 count after ack", int'(pend_cnt_o), 1);
    drive(3'd2, 8'sd1, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0); #1;
    chk("R10 ack last evt", int'(evt_o), 6);
    step();
    chk("R10 count zero", int'(pend_cnt_o), 0);

    // R10: acks first, then data
    drive(3'd2, 8'sd1, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0); #1;
    chk("R10 early ack evt", int'(evt_o), 5);
    step();
    chk("R10 count -1", int'(pend_cnt_o), -1);
    drive(3'd2, 8'sd1, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0); #1;
    chk("R10 early ack2 evt", int'(evt_o), 5);
    step();
    chk("R10 count -2", int'(pend_cnt_o), -2);
    drive(3'd0, -8'sd2, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0); #1;
    chk("R10 late data evt", int'(evt_o), 4);
    step();
    chk("R10 count balanced", int'(pend_cnt_o), 0);

    // R8: non-settling pops leave the count
    drive(3'd2, 8'sd3, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0);
    step();
    chk("R8 count -3", int'(pend_cnt_o), -3);
    drive(3'd3, 8'sd1, 1'b0, 4'd9, 1'b1, 1'b1, 1'b0);
    step();
    chk("R8 wb ack pop holds", int'(pend_cnt_o), -3);
    drive(3'd1, 8'sd5, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0);
    step();
    chk("R8 excl pop holds", int'(pend_cnt_o), -3);
    drive(3'd0, 8'sd2, 1'b1, 4'd5, 1'b1, 1'b1, 1'b0); #1;
    chk("R3 peer data evt", int'(evt_o), 3);
    step();
    chk("R8 peer data pop holds", int'(pend_cnt_o), -3);
    drive(3'd6, 8'sd2, 1'b0, 4'd7, 1'b1, 1'b1, 1'b0);
    step();
    chk("R7 bad kind pop holds", int'(pend_cnt_o), -3);

    // R11: pop without a valid response
    drive(3'd2, 8'sd1, 1'b0, 4'd7, 1'b0, 1'b1, 1'b0); #1;
    chk("R11 idle evt_valid", int'(evt_valid_o), 0);
    step();
    chk("R11 count held", int'(pend_cnt_o), -3);

    // R9: free beats pop
    drive(3'd2, 8'sd1, 1'b0, 4'd7, 1'b1, 1'b1, 1'b1);
    step();
    chk("R9 free clears", int'(pend_cnt_o), 0);
    drive(3'd0, 8'sd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    step();
    chk("R9 stays zero", int'(pend_cnt_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule